// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block sits at the front of a Reed-Solomon decoder over GF(2^8). It takes a received block one 8-bit symbol per clock and forms the six syndromes of a code whose generator roots are alpha^0 to alpha^5. Syndrome j is the received polynomial evaluated at alpha^j. All six are zero exactly when the received word is divisible by the generator, so a combined clean flag lets the later error-locator stage be skipped for error-free blocks.

Symbols arrive highest-degree coefficient first. A qualifier marks each symbol as present, and start and end markers frame the block. Six Horner accumulators run side by side. The block may be full length (255 symbols) or shortened, and it needs no zero padding. When the final symbol is taken, all six results and the clean flag are captured into an output register. A done strobe marks that capture, so the next block can start in the very next cycle.

Top module: `rs_syndrome_calc`

## Requirements
- R1: After reset, out_done and out_clean are 0 and all bits of out_syn are 0.
- R2: Syndrome j equals the XOR over received symbols r_i of r_i times alpha^(j*d_i). Here d_i is the symbol's degree: the last symbol has degree 0 and each earlier symbol has one more. The field uses the polynomial x^8+x^4+x^3+x^2+1, and alpha is the element 0x02.
- R3: Syndrome j is placed on out_syn bits [8*j+7 : 8*j], for j = 0 to 5.
- R4: A symbol taken with in_sop high starts a new block. Whatever was accumulated before it is discarded.
- R5: Cycles with in_valid low leave the accumulation unchanged. A block may contain gaps, and the gaps do not change its syndromes.
- R6: out_done is high for exactly the one cycle after the edge at which a symbol is taken with in_eop high, and it is low at all other times.
- R7: out_clean is 1 when all six captured syndromes are zero, and 0 otherwise. A valid codeword gives out_clean = 1.
- R8: out_syn and out_clean keep their values until the next block end is captured.
- R9: A new block may start (in_sop) in the cycle right after in_eop. Both blocks then produce correct results.
- R10: Leading zero symbols do not change the result. A block of one symbol (in_sop and in_eop together) gives all six syndromes equal to that symbol.
- R11: Syndrome 0 equals the XOR of all symbols of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A symbol is present on in_sym |
| in_sop | input | 1 | The symbol is the first of its block |
| in_eop | input | 1 | The symbol is the last of its block |
| in_sym | input | 8 | Received symbol, highest degree first |
| out_done | output | 1 | One-cycle strobe: new results captured |
| out_clean | output | 1 | All captured syndromes are zero |
| out_syn | output | 48 | Six captured syndromes, syndrome j in byte j |

## Verification
Blocks of random symbols exercise every multiplier power against an independent power-sum model built on log and antilog tables. Generated codewords must give a clean result. Copies of those codewords with one corrupted symbol, and copies with zeros prepended, separate a true divisibility test from a test that happens to pass. Blocks with gaps, back-to-back blocks, one-symbol blocks, full 255-symbol blocks and a restart in the middle of a block each check one framing rule: gap holding, restart loading, capture before the next block, and the range of the degree.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

    localparam int SYM_W      = 8;
    localparam int FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;

    // GF(2^8) product, shift-and-add with reduction on overflow
    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        logic [SYM_W:0] acc_sh;
        sym_t           res;
        res    = '0;
        acc_sh = {1'b0, a};
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) res = res ^ acc_sh[SYM_W-1:0];
            acc_sh = acc_sh << 1;
            if (acc_sh[SYM_W]) acc_sh = acc_sh ^ FIELD_POLY[SYM_W:0];
        end
        return res;
    endfunction

    // alpha^e with alpha = 0x02
    function automatic sym_t alpha_pow(input int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

endpackage

// File: rtl/rs_syn_cmul.sv
module rs_syn_cmul
    import rs_syn_pkg::*;
#(
    parameter int POW = 1
) (
    input  sym_t x_i,
    output sym_t y_o
);
    generate
        if (POW == 0) begin : g_unity
            // alpha^0 is one: the product is the input itself
            assign y_o = x_i;
        end else begin : g_matrix
            localparam sym_t COEF = alpha_pow(POW);
            sym_t cols [SYM_W];
            for (genvar b = 0; b < SYM_W; b++) begin : g_col
                assign cols[b] = gf_mul(COEF, sym_t'(1) << b);
            end
            always_comb begin
                y_o = '0;
                for (int b = 0; b < SYM_W; b++) begin
                    if (x_i[b]) y_o = y_o ^ cols[b];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rs_syn_horner_cell.sv
module rs_syn_horner_cell
    import rs_syn_pkg::*;
#(
    parameter int ROOT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_vld,
    input  logic sym_first,
    input  sym_t sym_in,
    output sym_t acc_o,
    output sym_t acc_next_o
);
    typedef struct packed {
        sym_t acc;
    } cell_st_t;

    cell_st_t st_d, st_q;
    sym_t     scaled;
    sym_t     step_val;

    rs_syn_cmul #(.POW(ROOT)) u_cmul (
        .x_i (st_q.acc),
        .y_o (scaled)
    );

    always_comb begin
        st_d     = st_q;
        step_val = sym_first ? sym_in : (scaled ^ sym_in);
        if (sym_vld) st_d.acc = step_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o      = st_q.acc;
    assign acc_next_o = step_val;

    AST_SOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && sym_first) |=> (acc_o == $past(sym_in))); // R4

    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_vld |=> $stable(acc_o)); // R5

    generate
        if (ROOT == 0) begin : g_par_chk
            AST_S0_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_vld && !sym_first) |=> (acc_o == ($past(acc_o) ^ $past(sym_in)))); // R11
        end
    endgenerate
endmodule

// File: rtl/rs_syn_zero_det.sv
module rs_syn_zero_det #(
    parameter int NUM_SYN = 6,
    parameter int SYM_W   = 8
) (
    input  logic [NUM_SYN*SYM_W-1:0] syn_i,
    output logic                     all_zero_o
);
    logic [NUM_SYN-1:0] nz;
    for (genvar j = 0; j < NUM_SYN; j++) begin : g_nz
        assign nz[j] = |syn_i[j*SYM_W +: SYM_W];
    end
    assign all_zero_o = ~|nz;
endmodule

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc
    import rs_syn_pkg::*;
#(
    parameter int NUM_SYN = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic [SYM_W-1:0]         in_sym,
    output logic                     out_done,
    output logic                     out_clean,
    output logic [NUM_SYN*SYM_W-1:0] out_syn
);
    localparam int SYN_BITS = NUM_SYN * SYM_W;

    typedef struct packed {
        logic                done;
        logic                clean;
        logic [SYN_BITS-1:0] syn;
    } out_st_t;

    out_st_t             out_d, out_q;
    logic [SYN_BITS-1:0] next_all;
    logic [SYN_BITS-1:0] held_all;
    logic                next_zero;
    logic                capture;

    for (genvar j = 0; j < NUM_SYN; j++) begin : g_cell
        rs_syn_horner_cell #(.ROOT(j)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .sym_vld    (in_valid),
            .sym_first  (in_sop),
            .sym_in     (in_sym),
            .acc_o      (held_all[j*SYM_W +: SYM_W]),
            .acc_next_o (next_all[j*SYM_W +: SYM_W])
        );
    end

    rs_syn_zero_det #(.NUM_SYN(NUM_SYN), .SYM_W(SYM_W)) u_zdet (
        .syn_i      (next_all),
        .all_zero_o (next_zero)
    );

    assign capture = in_valid && in_eop;

    always_comb begin
        out_d      = out_q;
        out_d.done = capture;
        if (capture) begin
            out_d.syn   = next_all;
            out_d.clean = next_zero;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_done  = out_q.done;
    assign out_clean = out_q.clean;
    assign out_syn   = out_q.syn;

    AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> (out_clean == (out_syn == '0))); // R7

    AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> out_done); // R6

    AST_DONE_ONLY_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eop) |=> !out_done); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eop) |=> ($stable(out_syn) && $stable(out_clean))); // R8

    AST_CAPTURE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> (out_syn == $past(next_all))); // R2
endmodule

// File: tb/sim_rs_syndrome_calc.sv
`timescale 1ns/1ps
module sim_rs_syndrome_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [7:0]  in_sym = '0;
    logic        out_done;
    logic        out_clean;
    logic [47:0] out_syn;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    string cur_tag = "R2";

    always #4 clk = ~clk;

    rs_syndrome_calc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_sym(in_sym), .out_done(out_done),
        .out_clean(out_clean), .out_syn(out_syn)
    );

    // log / antilog tables
    int gexp [0:254];
    int glog [0:255];
    initial begin
        int v;
        v = 1;
        for (int i = 0; i < 255; i++) begin
            gexp[i] = v;
            glog[v] = i;
            v = v << 1;
            if ((v & 256) != 0) v = v ^ 285;
        end
        glog[0] = 0;
    end

    function automatic int gmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return gexp[(glog[a] + glog[b]) % 255];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // behavioural model
    logic [7:0] blk_q[$];
    int  e_syn [6];
    bit  e_done = 0;
    bit  e_clean = 0;
    int  e_par = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            blk_q.delete();
            for (int j = 0; j < 6; j++) e_syn[j] = 0;
            e_done = 0; e_clean = 0; e_par = 0;
        end else begin
            e_done = 0;
            if (in_valid) begin
                if (in_sop) blk_q.delete();
                blk_q.push_back(in_sym);
                if (in_eop) begin
                    int n;
                    n = blk_q.size();
                    e_clean = 1; e_par = 0;
                    for (int j = 0; j < 6; j++) begin
                        int s;
                        s = 0;
                        for (int i = 0; i < n; i++) begin
                            int d;
                            d = n - 1 - i;
                            s = s ^ gmul(int'(blk_q[i]), gexp[(j * d) % 255]);
                        end
                        e_syn[j] = s;
                        if (s != 0) e_clean = 0;
                    end
                    for (int i = 0; i < n; i++) e_par = e_par ^ int'(blk_q[i]);
                    e_done = 1;
                end
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(out_done == e_done, "R6", out_done, e_done);
            for (int j = 0; j < 6; j++)
                chk(int'(out_syn[j*8 +: 8]) == e_syn[j], e_done ? cur_tag : "R8",
                    out_syn[j*8 +: 8], e_syn[j]);
            chk(out_clean == e_clean, "R7", out_clean, e_clean);
            if (e_done) chk(int'(out_syn[7:0]) == e_par, "R11", out_syn[7:0], e_par);
        end
    end

    task automatic send(input logic [7:0] s, input bit sop, input bit eop);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_sym = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_sym = $urandom;
        end
    endtask

    task automatic send_block(input logic [7:0] b[$], input int gap);
        for (int i = 0; i < b.size(); i++) begin
            send(b[i], i == 0, i == b.size() - 1);
            if (gap > 0 && ((i + 1) % gap) == 0 && i != b.size() - 1) idle(1);
        end
    endtask

    function automatic void rand_block(output logic [7:0] b[$], input int n);
        b.delete();
        for (int i = 0; i < n; i++) b.push_back(8'($urandom));
    endfunction

    // codeword c(x) = g(x) * m(x), returned highest degree first
    function automatic void make_cw(output logic [7:0] b[$], input int k);
        int g[$];
        int m[$];
        int c[$];
        g.push_back(1);
        for (int j = 0; j < 6; j++) begin
            int ng[$];
            for (int i = 0; i <= g.size(); i++) begin
                int lo, hi;
                lo = (i < g.size()) ? gmul(g[i], gexp[j]) : 0;
                hi = (i > 0) ? g[i-1] : 0;
                ng.push_back(lo ^ hi);
            end
            g = ng;
        end
        for (int i = 0; i < k; i++) m.push_back(1 + ($urandom % 255));
        for (int i = 0; i < k + 6; i++) c.push_back(0);
        for (int i = 0; i < k; i++)
            for (int t = 0; t < 7; t++) c[i+t] = c[i+t] ^ gmul(m[i], g[t]);
        b.delete();
        for (int i = k + 5; i >= 0; i--) b.push_back(8'(c[i]));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] b[$];
        logic [7:0] z[$];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_done == 1'b0, "R1", out_done, 0);
        chk(out_clean == 1'b0, "R1", out_clean, 0);
        chk(out_syn == '0, "R1", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        cur_tag = "R2 R3";
        for (int t = 0; t < 4; t++) begin rand_block(b, 10 + t * 7); send_block(b, 0); idle(2); end

        cur_tag = "R7";
        make_cw(b, 12); send_block(b, 0); idle(2);
        chk(out_clean == 1'b1, "R7", out_clean, 1);
        b[5] = b[5] ^ 8'h5A; send_block(b, 0); idle(2);
        chk(out_clean == 1'b0, "R7", out_clean, 0);

        cur_tag = "R5";
        rand_block(b, 15); send_block(b, 3); idle(2);
        make_cw(b, 9); send_block(b, 2); idle(2);
        chk(out_clean == 1'b1, "R5", out_clean, 1);

        cur_tag = "R10";
        make_cw(b, 8);
        z = {8'h00, 8'h00, 8'h00, 8'h00};
        z = {z, b};
        send_block(z, 0); idle(2);
        chk(out_clean == 1'b1, "R10", out_clean, 1);
        send(8'hC3, 1, 1); idle(2);
        for (int j = 0; j < 6; j++) chk(out_syn[j*8 +: 8] == 8'hC3, "R10", out_syn[j*8 +: 8], 8'hC3);

        cur_tag = "R4";
        for (int i = 0; i < 7; i++) send(8'($urandom), i == 0, 0);
        make_cw(b, 10); send_block(b, 0); idle(2);
        chk(out_clean == 1'b1, "R4", out_clean, 1);

        cur_tag = "R9";
        for (int t = 0; t < 5; t++) begin
            if (t == 2) begin b.delete(); b.push_back(8'($urandom)); end
            else if (t == 3) make_cw(b, 6);
            else rand_block(b, 5 + t);
            send_block(b, 0);
        end
        idle(3);

        cur_tag = "R2 R3";
        make_cw(b, 249); send_block(b, 0); idle(2);
        chk(out_clean == 1'b1, "R2", out_clean, 1);
        rand_block(b, 255); send_block(b, 0); idle(3);

        cur_tag = "R8";
        idle(5);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule